// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit controller core, together with the status register that records its flags. Each cycle it takes an operation code and two 8-bit operands. The carry input is the C bit already held in the status register. The block returns the 8-bit result combinationally. When the operation is marked valid, it writes the carry, nibble carry, zero and overflow flags that the operation defines into the status register at the next clock edge.

The same register also holds two protected system flags. One records a power-down entry and the other records a watchdog expiry. Software can read and write the register like any other byte. A write changes only the four arithmetic flags. The two system flags move only on dedicated event strobes: power-up, watchdog clear, halt entry and watchdog timeout. Subtraction keeps the carry as an inverted borrow, and decimal adjust uses the nibble carry of the previous addition. The surrounding core decodes instructions and saves the status register around calls and interrupts. This block does not save it.

Top module: `alu_status_unit`

## Requirements
- R1: A synchronous active-high reset clears every status bit to 0.
- R2: Status layout is C bit 0, AC bit 1, Z bit 2, OV bit 3, PDF bit 4, TO bit 5. Bits 7 and 6 always read 0.
- R3: Codes 0 (add) and 1 (add with carry) give A+B and A+B+C. C is the carry out of bit 7, AC is the carry out of bit 3, OV is the carry into bit 7 XOR the carry out of bit 7, and Z is set when the result is 0.
- R4: Codes 2 (subtract) and 3 (subtract with carry) give A+~B+1 and A+~B+C. C=1 means no borrow, and AC=1 means no borrow out of the low nibble. OV and Z follow the rule in R3.
- R5: Code 4 (decimal adjust of A) adds 0x06 when A[3:0] > 9 or AC=1. It then adds 0x60 when the upper nibble of that intermediate byte is > 9 or C=1. C becomes old C OR a carry out of either addition. No other flag changes.
- R6: Codes 5 AND, 6 OR, 7 XOR (of A and B) and 8 (complement of A) update only Z.
- R7: Codes 9 (rotate A left) and 10 (rotate A right) change no flag.
- R8: Code 11 gives {A[6:0],C} and loads C from A[7]. Code 12 gives {C,A[7:1]} and loads C from A[0]. No other flag changes.
- R9: Codes 13 (A+1) and 14 (A-1) wrap modulo 256 and update only Z.
- R10: Code 15 passes A through and changes no flag. With op_valid low, no flag changes.
- R11: A status write loads bits 3..0 from the write data. PDF and TO ignore the write.
- R12: When a write and a valid operation meet in one cycle, the operation's flag updates override the write, and the write still reaches the flags the operation leaves alone.
- R13: PDF is cleared by power-up or watchdog clear and is set by halt. The clear wins when clear and halt come together.
- R14: TO is cleared by power-up. Otherwise a timeout sets it, and otherwise watchdog clear or halt clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Commit this cycle's flag updates |
| op_code | input | 4 | Operation select |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| result | output | 8 | Combinational result |
| stat_we | input | 1 | Status register write strobe |
| stat_wdata | input | 8 | Status write data |
| evt_powerup | input | 1 | Power-up event |
| evt_clrwdt | input | 1 | Watchdog clear event |
| evt_halt | input | 1 | Halt entry event |
| evt_wdt_timeout | input | 1 | Watchdog expiry event |
| status | output | 8 | Status register contents |

## Verification
The assertions check on every cycle that the two top bits stay zero and that PDF and TO hold without an event. They also check that each event drives its flag, that plain writes land in the low nibble, and that rotates and logic operations touch only the flags they own. The arithmetic values themselves are left to the bench. Those are the sums, the borrow polarity, the nibble carry, overflow and the two-step decimal correction. The bench sweeps every A against a spread of B values and carry and nibble-carry states, and it runs the event combinations that collide in one cycle.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int MID_W  = DATA_W - NIB_W - 1;
    localparam int FLAG_N = 4;
    localparam int SYS_N  = 2;
    localparam int STAT_W = 8;
    localparam int BIT_PDF = FLAG_N;
    localparam int BIT_TO  = FLAG_N + 1;

    localparam logic [NIB_W-1:0]  BCD_MAX    = NIB_W'(9);
    localparam logic [DATA_W:0]   DEC_LO_ADJ = (DATA_W+1)'(6);
    localparam logic [DATA_W:0]   DEC_HI_ADJ = (DATA_W+1)'(6) << NIB_W;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,  OP_ADC  = 4'd1,  OP_SUB  = 4'd2,  OP_SBC  = 4'd3,
        OP_DAA  = 4'd4,  OP_AND  = 4'd5,  OP_OR   = 4'd6,  OP_XOR  = 4'd7,
        OP_CPL  = 4'd8,  OP_RL   = 4'd9,  OP_RR   = 4'd10, OP_RLC  = 4'd11,
        OP_RRC  = 4'd12, OP_INC  = 4'd13, OP_DEC  = 4'd14, OP_PASS = 4'd15
    } alu_op_e;

    // field order matches status bits 3..0
    typedef struct packed {
        logic ov;
        logic z;
        logic ac;
        logic c;
    } flags_t;

    typedef struct packed {
        logic power_up;
        logic clr_wdt;
        logic halt;
        logic wdt_timeout;
    } sys_evt_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        flags_t            flags;
    } alu_res_t;

    function automatic flags_t upd_mask(alu_op_e op);
        flags_t m;
        m = '0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: m = '{ov: 1'b1, z: 1'b1, ac: 1'b1, c: 1'b1};
            OP_DAA, OP_RLC, OP_RRC:         m.c = 1'b1;
            OP_AND, OP_OR, OP_XOR, OP_CPL,
            OP_INC, OP_DEC:                 m.z = 1'b1;
            default:                        m = '0;
        endcase
        return m;
    endfunction

    function automatic logic is_zero(logic [DATA_W-1:0] v);
        return v == '0;
    endfunction

    function automatic logic is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) || (op == OP_SBC);
    endfunction
endpackage

// File: rtl/alu_adder.sv
module alu_adder
    import alu8_pkg::*;
(
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output alu_res_t          res
);
    logic              sub_sel;
    logic              use_c;
    logic              c0;
    logic [DATA_W-1:0] b_eff;
    logic [NIB_W:0]    lo_sum;
    logic [MID_W:0]    mid_sum;
    logic [1:0]        top_sum;

    assign sub_sel = (op == OP_SUB) || (op == OP_SBC);
    assign use_c   = (op == OP_ADC) || (op == OP_SBC);
    assign b_eff   = sub_sel ? ~b : b;
    assign c0      = use_c ? cin : sub_sel;

    // split chain: low nibble, middle bits, sign bit
    assign lo_sum  = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
                   + {{NIB_W{1'b0}}, c0};
    assign mid_sum = {1'b0, a[DATA_W-2:NIB_W]} + {1'b0, b_eff[DATA_W-2:NIB_W]}
                   + {{MID_W{1'b0}}, lo_sum[NIB_W]};
    assign top_sum = {1'b0, a[DATA_W-1]} + {1'b0, b_eff[DATA_W-1]} + {1'b0, mid_sum[MID_W]};

    always_comb begin
        res.value    = {top_sum[0], mid_sum[MID_W-1:0], lo_sum[NIB_W-1:0]};
        res.flags.c  = top_sum[1];
        res.flags.ac = lo_sum[NIB_W];
        res.flags.ov = top_sum[1] ^ mid_sum[MID_W];
        res.flags.z  = is_zero(res.value);
    end
endmodule

// File: rtl/alu_decadj.sv
module alu_decadj
    import alu8_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic              ac_in,
    input  logic              c_in,
    output logic [DATA_W-1:0] value,
    output logic              c_out
);
    logic              lo_fix;
    logic              hi_fix;
    logic [DATA_W:0]   step1;
    logic [DATA_W:0]   step2;

    assign lo_fix = (a[NIB_W-1:0] > BCD_MAX) || ac_in;
    assign step1  = {1'b0, a} + (lo_fix ? DEC_LO_ADJ : '0);
    assign hi_fix = (step1[DATA_W-1:NIB_W] > BCD_MAX) || c_in;
    assign step2  = {1'b0, step1[DATA_W-1:0]} + (hi_fix ? DEC_HI_ADJ : '0);

    assign value = step2[DATA_W-1:0];
    assign c_out = c_in | step1[DATA_W] | step2[DATA_W];
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
    import alu8_pkg::*;
(
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] value,
    output logic              c_out
);
    always_comb begin
        value = a;
        c_out = cin;
        unique case (op)
            OP_AND: value = a & b;
            OP_OR:  value = a | b;
            OP_XOR: value = a ^ b;
            OP_CPL: value = ~a;
            OP_RL:  value = {a[DATA_W-2:0], a[DATA_W-1]};
            OP_RR:  value = {a[0], a[DATA_W-1:1]};
            OP_RLC: begin
                value = {a[DATA_W-2:0], cin};
                c_out = a[DATA_W-1];
            end
            OP_RRC: begin
                value = {cin, a[DATA_W-1:1]};
                c_out = a[0];
            end
            OP_INC: value = a + DATA_W'(1);
            OP_DEC: value = a - DATA_W'(1);
            default: value = a;
        endcase
    end
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [FLAG_N-1:0] wr_flags,
    input  flags_t            upd_en,
    input  flags_t            upd_val,
    input  sys_evt_t          evt,
    output logic [STAT_W-1:0] q
);
    localparam int HELD_W = FLAG_N + SYS_N;

    logic [HELD_W-1:0] cur;
    logic [HELD_W-1:0] nxt;
    logic [FLAG_N-1:0] en_v;
    logic [FLAG_N-1:0] val_v;

    assign en_v  = upd_en;
    assign val_v = upd_val;

    always_comb begin
        nxt = cur;
        if (wr_en) nxt[FLAG_N-1:0] = wr_flags;
        for (int i = 0; i < FLAG_N; i++) begin
            if (en_v[i]) nxt[i] = val_v[i];
        end
        // power-down flag
        if (evt.power_up || evt.clr_wdt) nxt[BIT_PDF] = 1'b0;
        else if (evt.halt)               nxt[BIT_PDF] = 1'b1;
        // time-out flag
        if (evt.power_up)                nxt[BIT_TO] = 1'b0;
        else if (evt.wdt_timeout)        nxt[BIT_TO] = 1'b1;
        else if (evt.clr_wdt || evt.halt) nxt[BIT_TO] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign q = {{(STAT_W-HELD_W){1'b0}}, cur};
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result,
    input  logic              stat_we,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic              evt_powerup,
    input  logic              evt_clrwdt,
    input  logic              evt_halt,
    input  logic              evt_wdt_timeout,
    output logic [STAT_W-1:0] status
);
    alu_op_e           op;
    flags_t            cur_flags;
    alu_res_t          add_res;
    logic [DATA_W-1:0] dec_val;
    logic              dec_c;
    logic [DATA_W-1:0] bit_val;
    logic              bit_c;
    flags_t            new_flags;
    flags_t            upd_en;
    sys_evt_t          evt;
    logic [STAT_W-FLAG_N-1:0] wdata_unused_hi;

    assign op              = alu_op_e'(op_code);
    assign cur_flags       = status[FLAG_N-1:0];
    assign wdata_unused_hi = stat_wdata[STAT_W-1:FLAG_N];

    alu_adder u_adder (
        .op  (op),
        .a   (opnd_a),
        .b   (opnd_b),
        .cin (cur_flags.c),
        .res (add_res)
    );

    alu_decadj u_decadj (
        .a     (opnd_a),
        .ac_in (cur_flags.ac),
        .c_in  (cur_flags.c),
        .value (dec_val),
        .c_out (dec_c)
    );

    alu_bitops u_bitops (
        .op    (op),
        .a     (opnd_a),
        .b     (opnd_b),
        .cin   (cur_flags.c),
        .value (bit_val),
        .c_out (bit_c)
    );

    always_comb begin
        if (is_arith(op)) begin
            result    = add_res.value;
            new_flags = add_res.flags;
        end else begin
            result       = (op == OP_DAA) ? dec_val : bit_val;
            new_flags.c  = (op == OP_DAA) ? dec_c : bit_c;
            new_flags.ac = add_res.flags.ac;
            new_flags.ov = add_res.flags.ov;
            new_flags.z  = is_zero(result);
        end
    end

    assign upd_en = op_valid ? upd_mask(op) : '0;
    assign evt    = '{power_up: evt_powerup, clr_wdt: evt_clrwdt,
                      halt: evt_halt, wdt_timeout: evt_wdt_timeout};

    alu_status_reg u_status (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (stat_we),
        .wr_flags (stat_wdata[FLAG_N-1:0]),
        .upd_en   (upd_en),
        .upd_val  (new_flags),
        .evt      (evt),
        .q        (status)
    );
endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk
    import alu8_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] result,
    input logic              stat_we,
    input logic [STAT_W-1:0] stat_wdata,
    input logic              evt_powerup,
    input logic              evt_clrwdt,
    input logic              evt_halt,
    input logic              evt_wdt_timeout,
    input logic [STAT_W-1:0] status
);
    logic no_evt;
    logic is_logic_op;
    logic is_plain_rot;
    assign no_evt       = !evt_powerup && !evt_clrwdt && !evt_halt && !evt_wdt_timeout;
    assign is_logic_op  = (op_code == OP_AND) || (op_code == OP_OR)
                       || (op_code == OP_XOR) || (op_code == OP_CPL);
    assign is_plain_rot = (op_code == OP_RL) || (op_code == OP_RR);

    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (rst)
        status[STAT_W-1:BIT_TO+1] == '0);

    assert_sys_hold_R11: assert property (@(posedge clk) disable iff (rst)
        no_evt |=> $stable(status[BIT_TO:BIT_PDF]));

    assert_write_low_R11: assert property (@(posedge clk) disable iff (rst)
        (stat_we && !op_valid) |=> status[FLAG_N-1:0] == $past(stat_wdata[FLAG_N-1:0]));

    assert_logic_z_R6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && is_logic_op) |=> status[2] == ($past(result) == '0));

    assert_rot_noflag_R7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && is_plain_rot && !stat_we) |=> $stable(status[FLAG_N-1:0]));

    assert_rlc_carry_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_RLC) |=> status[0] == $past(opnd_a[DATA_W-1]));

    assert_halt_pdf_R13: assert property (@(posedge clk) disable iff (rst)
        (evt_halt && !evt_powerup && !evt_clrwdt) |=> status[BIT_PDF]);

    assert_powerup_clear_R13: assert property (@(posedge clk) disable iff (rst)
        evt_powerup |=> status[BIT_TO:BIT_PDF] == 2'b00);

    assert_timeout_to_R14: assert property (@(posedge clk) disable iff (rst)
        (evt_wdt_timeout && !evt_powerup) |=> status[BIT_TO]);
endmodule

bind alu_status_unit alu_status_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .op_valid        (op_valid),
    .op_code         (op_code),
    .opnd_a          (opnd_a),
    .result          (result),
    .stat_we         (stat_we),
    .stat_wdata      (stat_wdata),
    .evt_powerup     (evt_powerup),
    .evt_clrwdt      (evt_clrwdt),
    .evt_halt        (evt_halt),
    .evt_wdt_timeout (evt_wdt_timeout),
    .status          (status)
);

// File: tb/alu_status_unit_tb.sv
`timescale 1ns/1ps
module alu_status_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [7:0] opnd_a = 8'd0;
    logic [7:0] opnd_b = 8'd0;
    logic [7:0] result;
    logic       stat_we = 1'b0;
    logic [7:0] stat_wdata = 8'd0;
    logic       evt_powerup = 1'b0;
    logic       evt_clrwdt = 1'b0;
    logic       evt_halt = 1'b0;
    logic       evt_wdt_timeout = 1'b0;
    logic [7:0] status;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    alu_status_unit dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
        .stat_we(stat_we), .stat_wdata(stat_wdata),
        .evt_powerup(evt_powerup), .evt_clrwdt(evt_clrwdt),
        .evt_halt(evt_halt), .evt_wdt_timeout(evt_wdt_timeout),
        .status(status)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string req_of(int op);
        if (op <= 1)  return "R3";
        if (op <= 3)  return "R4";
        if (op == 4)  return "R5";
        if (op <= 8)  return "R6";
        if (op <= 10) return "R7";
        if (op <= 12) return "R8";
        if (op <= 14) return "R9";
        return "R10";
    endfunction

    // returns {flags[3:0], result[7:0]}; flags bit0 C, bit1 AC, bit2 Z, bit3 OV
    function automatic logic [11:0] model(int op, int a, int b, logic [3:0] fin);
        logic [3:0] f = fin;
        int r = a;
        int bb, ci, s, t, c1, c2;
        case (op)
            0, 1, 2, 3: begin
                bb = (op >= 2) ? ((~b) & 255) : b;
                ci = (op == 0) ? 0 : (op == 2) ? 1 : int'(fin[0]);
                s  = a + bb + ci;
                r  = s & 255;
                f[0] = (s > 255);
                f[1] = (((a & 15) + (bb & 15) + ci) > 15);
                f[2] = (r == 0);
                f[3] = ((((a ^ r) & (bb ^ r)) >> 7) & 1) != 0;
            end
            4: begin
                t  = a + ((((a & 15) > 9) || fin[1]) ? 6 : 0);
                c1 = (t > 255);
                t  = t & 255;
                s  = t + ((((t >> 4) > 9) || fin[0]) ? 96 : 0);
                c2 = (s > 255);
                r  = s & 255;
                f[0] = fin[0] | (c1 != 0) | (c2 != 0);
            end
            5:  begin r = a & b;         f[2] = (r == 0); end
            6:  begin r = a | b;         f[2] = (r == 0); end
            7:  begin r = a ^ b;         f[2] = (r == 0); end
            8:  begin r = (~a) & 255;    f[2] = (r == 0); end
            9:  r = ((a << 1) | (a >> 7)) & 255;
            10: r = ((a >> 1) | (a << 7)) & 255;
            11: begin r = ((a << 1) | int'(fin[0])) & 255; f[0] = a[7]; end
            12: begin r = (a >> 1) | (int'(fin[0]) << 7);  f[0] = a[0]; end
            13: begin r = (a + 1) & 255; f[2] = (r == 0); end
            14: begin r = (a + 255) & 255; f[2] = (r == 0); end
            default: r = a;
        endcase
        return {f, 8'(r)};
    endfunction

    task automatic run_op(int op, int a, int b, logic [3:0] pre);
        logic [11:0] exp;
        logic [7:0]  got_res;
        stat_we    = 1'b1;
        stat_wdata = {4'h0, pre};
        step();
        stat_we  = 1'b0;
        op_code  = 4'(op);
        opnd_a   = 8'(a);
        opnd_b   = 8'(b);
        op_valid = 1'b1;
        #1;
        got_res = result;
        exp = model(op, a, b, pre);
        step();
        op_valid = 1'b0;
        chk(req_of(op), {got_res, status}, {exp[7:0], 4'h0, exp[11:8]});
    endtask

    task automatic evt_cycle(logic pu, logic cw, logic hl, logic to);
        evt_powerup = pu; evt_clrwdt = cw; evt_halt = hl; evt_wdt_timeout = to;
        step();
        evt_powerup = 0; evt_clrwdt = 0; evt_halt = 0; evt_wdt_timeout = 0;
    endtask

    task automatic write_stat(logic [7:0] d);
        stat_we = 1'b1; stat_wdata = d;
        step();
        stat_we = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        step();
        step();
        rst = 1'b0;
        step();
        chk("R1 reset", {8'h00, status}, 16'h0000);

        // add / subtract families over all A and a spread of B
        for (int op = 0; op < 4; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b += 7) begin
                    run_op(op, a, b, {a[0] ^ b[1], b[0], a[1], a[2] ^ b[0]});
                end
            end
        end
        // decimal adjust with every C/AC state
        for (int a = 0; a < 256; a++) begin
            for (int fl = 0; fl < 4; fl++) begin
                run_op(4, a, 0, {a[0], a[1], fl[1], fl[0]});
            end
        end
        // logic operations
        for (int op = 5; op < 9; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b += 17) begin
                    run_op(op, a, b, {b[0], a[0], a[1], b[1]});
                end
            end
        end
        // rotates with both carry states
        for (int op = 9; op < 13; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int c = 0; c < 2; c++) begin
                    run_op(op, a, 0, {a[1], a[0], a[2], c[0]});
                end
            end
        end
        // increment, decrement, pass
        for (int op = 13; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
                run_op(op, a, 0, {a[3], a[0], a[1], a[2]});
            end
        end

        // R10: op_valid low leaves flags alone
        write_stat(8'h05);
        op_code = 4'd0; opnd_a = 8'hFF; opnd_b = 8'h01; op_valid = 1'b0;
        step();
        chk("R10 idle", {8'h00, status}, 16'h0005);

        // R12: write and operation in the same cycle
        write_stat(8'h00);
        stat_we = 1'b1; stat_wdata = 8'h0F;
        op_code = 4'd0; opnd_a = 8'h01; opnd_b = 8'h01; op_valid = 1'b1;
        step();
        chk("R12 add over write", {8'h00, status}, 16'h0000);
        stat_wdata = 8'h0F; op_code = 4'd5; opnd_a = 8'h0F; opnd_b = 8'hF0;
        step();
        chk("R12 and z over write", {8'h00, status}, 16'h000F);
        stat_wdata = 8'h0A; op_code = 4'd5; opnd_a = 8'hFF; opnd_b = 8'h01;
        step();
        chk("R12 write keeps others", {8'h00, status}, 16'h000A);
        stat_wdata = 8'h06; op_code = 4'd9; opnd_a = 8'h80;
        step();
        chk("R12 rotate write", {8'h00, status}, 16'h0006);
        stat_we = 1'b0; op_valid = 1'b0;

        // R2/R11: full write reaches only the low nibble
        write_stat(8'hFF);
        chk("R2 R11 write ff", {8'h00, status}, 16'h000F);

        // system flags
        evt_cycle(0, 0, 1, 0);
        chk("R13 halt sets pdf", {8'h00, status}, 16'h001F);
        evt_cycle(0, 0, 0, 1);
        chk("R14 timeout sets to", {8'h00, status}, 16'h003F);
        write_stat(8'h00);
        chk("R11 write keeps pdf to", {8'h00, status}, 16'h0030);
        evt_cycle(0, 0, 1, 0);
        chk("R14 halt clears to", {8'h00, status}, 16'h0010);
        evt_cycle(0, 0, 1, 1);
        chk("R14 timeout beats halt", {8'h00, status}, 16'h0030);
        evt_cycle(0, 1, 0, 0);
        chk("R13 clrwdt clears", {8'h00, status}, 16'h0000);
        evt_cycle(0, 1, 1, 0);
        chk("R13 clrwdt beats halt", {8'h00, status}, 16'h0000);
        evt_cycle(0, 0, 1, 1);
        evt_cycle(1, 0, 1, 1);
        chk("R13 R14 powerup clears", {8'h00, status}, 16'h0000);
        evt_cycle(0, 0, 0, 1);
        evt_cycle(0, 1, 0, 1);
        chk("R14 timeout beats clrwdt", {8'h00, status}, 16'h0020);

        // R1: reset clears everything
        write_stat(8'h0F);
        evt_cycle(0, 0, 1, 0);
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R1 reset clears", {8'h00, status}, 16'h0000);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule